// File: doc/BRIEF.md
# Skip-capable 8-bit ALU

This block evaluates one instruction of a small 8-bit controller per clock. It is given the 16-bit instruction word, the accumulator, an operand byte and the carry flag. The operand byte is either the memory byte the instruction addresses, the immediate byte, or the data read from an input port. From these it produces the result byte, where that result goes (accumulator or memory), the new carry, zero and negative flags, and a request to skip the next instruction.

The upper nibble of the instruction chooses the class. Six memory-operand classes choose the destination and a skip condition on the new zero flag. Two immediate classes always write the accumulator. Two bit-test opcodes and two bit-modify opcodes also belong to this block. Every other opcode does nothing here. Fetching operands, storing results, the program counter and bus timing belong to the surrounding controller. That controller applies the registered outputs one clock after it presents the instruction.

Top module: `skip_alu`

## Requirements
- R1: While reset is asserted and until the first valid instruction is registered, every output is 0.
- R2: Top nibbles 1010 to 1111 are ALU classes. Instruction bit 12 = 1 selects a memory write (mem_we_o=1, dest_mem_o=1); bit 12 = 0 selects an accumulator write (acc_we_o=1, dest_mem_o=0). Top nibbles 1000 and 1001 with operation codes 0 to D always write the accumulator. Bits 11:8 give the operation code.
- R3: Code 0 gives the operand when the destination is the accumulator and gives the accumulator when the destination is memory. Code 1 gives A XOR operand, code 2 gives A AND operand, code 3 gives A OR operand. All four pass carry_i unchanged to carry_o.
- R4: Code 4 shifts the operand left with 0 in bit 0. Code 5 shifts it left with the old carry in bit 0. Both take the new carry from operand bit 7. Code 6 shifts the operand right with 0 in bit 7. Code 7 shifts it right with the old carry in bit 7. Both take the new carry from operand bit 0.
- R5: Code 8 gives A+operand. Code C gives A+operand+carry. For both, the carry is set when the sum exceeds 255. Code 9 gives A-operand, with the carry set when A >= operand. Code D gives A-operand+carry, with the carry set when A+carry >= operand.
- R6: Code A gives operand-1, code B gives operand+1, code E gives FFh and code F gives 00h. All four leave the carry unchanged.
- R7: For every ALU-class instruction and for input-port loads, flag_we_o=1, zero_o is 1 exactly when the result is 00h, and neg_o equals result bit 7. Otherwise flag_we_o, zero_o and neg_o are 0.
- R8: Top nibbles 1111 and 1110 skip when the new zero flag is clear. Nibbles 1101 and 1100 skip when it is set. Nibbles 1011 and 1010 never skip. No immediate instruction skips.
- R9: Opcodes 1000 1110 (return) and 1000 1111 (return from interrupt) and 1001 1110 (port output) write nothing, update no flags and pass the carry through. Opcode 1001 1111 (port input) loads the operand into the accumulator.
- R10: Nibble 0101 skips when operand bit instr[10:8] is 0. Nibble 0100 skips when that bit is 1. Neither writes anything or changes the flags.
- R11: Nibble 0011 writes to memory the operand with bit instr[10:8] set. Nibble 0010 writes to memory the operand with that bit cleared. Neither updates the flags, and both pass the carry through.
- R12: Nibbles 0000, 0001, 0110 and 0111 do nothing: no write, no skip, no flag update, result 00h, carry passed through.
- R13: Outputs for an instruction appear on the clock after it is presented with in_valid=1. A cycle with in_valid=0 produces all-zero outputs on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 16 | Instruction word |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Memory, immediate or port operand |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Registered outputs belong to a valid instruction |
| result_o | output | 8 | Result byte |
| dest_mem_o | output | 1 | Result is destined for memory |
| acc_we_o | output | 1 | Write result to accumulator |
| mem_we_o | output | 1 | Write result to memory |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | New zero flag |
| neg_o | output | 1 | New negative flag |
| flag_we_o | output | 1 | Zero and negative flags are updated |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The block has one register stage, so a wrong decode or arithmetic value shows on the ports on the clock right after the offending instruction. It can show as a wrong write enable, a flipped skip, a wrong carry or a bad result byte, and nothing carries over into later instructions. The bench therefore compares every output on every clock against a behavioural model. It mixes in idle cycles so that an enable or skip that leaks from a previous instruction is caught at once. Directed operands cover carry-out, borrow, equal-operand subtraction, zero results that flip skip decisions, and every bit index for the bit instructions.

// File: rtl/skip_alu_pkg.sv
package skip_alu_pkg;

    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int BIDX_W  = 3;

    // Operation codes carried in instruction bits 11:8
    localparam logic [OP_W-1:0] OP_MOVE = 4'h0;
    localparam logic [OP_W-1:0] OP_XOR  = 4'h1;
    localparam logic [OP_W-1:0] OP_AND  = 4'h2;
    localparam logic [OP_W-1:0] OP_OR   = 4'h3;
    localparam logic [OP_W-1:0] OP_SHL  = 4'h4;
    localparam logic [OP_W-1:0] OP_SHLC = 4'h5;
    localparam logic [OP_W-1:0] OP_SHR  = 4'h6;
    localparam logic [OP_W-1:0] OP_SHRC = 4'h7;
    localparam logic [OP_W-1:0] OP_ADD  = 4'h8;
    localparam logic [OP_W-1:0] OP_SUB  = 4'h9;
    localparam logic [OP_W-1:0] OP_DEC  = 4'hA;
    localparam logic [OP_W-1:0] OP_INC  = 4'hB;
    localparam logic [OP_W-1:0] OP_ADDC = 4'hC;
    localparam logic [OP_W-1:0] OP_SUBC = 4'hD;
    localparam logic [OP_W-1:0] OP_ONES = 4'hE;
    localparam logic [OP_W-1:0] OP_ZERO = 4'hF;

    typedef enum logic [2:0] {
        CL_NOP,
        CL_ALU,
        CL_PORTIN,
        CL_BTEST,
        CL_BMOD
    } cls_e;

    typedef enum logic [1:0] {
        ZS_NEVER,
        ZS_ON_CLEAR,
        ZS_ON_SET
    } zskip_e;

    typedef struct packed {
        cls_e              cls;
        logic [OP_W-1:0]   op;
        logic              to_mem;
        zskip_e            zskip;
        logic [BIDX_W-1:0] bidx;
        logic              bval;
    } dec_t;

endpackage

// File: rtl/skip_alu_decode.sv
module skip_alu_decode
    import skip_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic [3:0]      nib;
    logic [OP_W-1:0] op;
    logic            special_op;

    assign nib        = instr[15:12];
    assign op         = instr[11:8];
    assign special_op = (op == OP_ONES) || (op == OP_ZERO);

    always_comb begin
        dec        = '0;
        dec.cls    = CL_NOP;
        dec.zskip  = ZS_NEVER;
        dec.op     = op;
        dec.bidx   = instr[10:8];
        if (nib[3] && (nib[2] || nib[1])) begin
            // memory-operand classes 1010..1111
            dec.cls    = CL_ALU;
            dec.to_mem = nib[0];
            if (nib[2]) begin
                dec.zskip = nib[1] ? ZS_ON_CLEAR : ZS_ON_SET;
            end
        end else if (nib[3:1] == 3'b100) begin
            // immediate classes 1000 / 1001
            if (!special_op) begin
                dec.cls = CL_ALU;
            end else if (nib[0] && (op == OP_ZERO)) begin
                dec.cls = CL_PORTIN;
            end
        end else if (nib[3:1] == 3'b010) begin
            // bit test: 0101 skips on clear, 0100 skips on set
            dec.cls  = CL_BTEST;
            dec.bval = ~nib[0];
        end else if (nib[3:1] == 3'b001) begin
            // bit modify: 0011 sets, 0010 clears
            dec.cls  = CL_BMOD;
            dec.bval = nib[0];
        end
    end

endmodule

// File: rtl/skip_alu_core.sv
module skip_alu_core
    import skip_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic            to_mem,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   x,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            cout
);

    localparam int XW = DW + 2;

    logic [XW-1:0] a_x;
    logic [XW-1:0] x_x;
    logic [XW-1:0] nx_x;
    logic [XW-1:0] c_x;
    logic [XW-1:0] one_x;
    logic [XW-1:0] sum_t;
    logic [XW-1:0] diff_t;

    assign a_x   = {2'b00, a};
    assign x_x   = {2'b00, x};
    assign nx_x  = {2'b00, ~x};
    assign c_x   = {{(XW-1){1'b0}}, cin};
    assign one_x = {{(XW-1){1'b0}}, 1'b1};

    always_comb begin
        sum_t  = a_x + x_x;
        diff_t = a_x + nx_x + one_x;
        if (op == OP_ADDC) begin
            sum_t = sum_t + c_x;
        end
        if (op == OP_SUBC) begin
            diff_t = diff_t + c_x;
        end
    end

    always_comb begin
        res  = '0;
        cout = cin;
        case (op)
            OP_MOVE: res = to_mem ? a : x;
            OP_XOR:  res = a ^ x;
            OP_AND:  res = a & x;
            OP_OR:   res = a | x;
            OP_SHL: begin
                res  = {x[DW-2:0], 1'b0};
                cout = x[DW-1];
            end
            OP_SHLC: begin
                res  = {x[DW-2:0], cin};
                cout = x[DW-1];
            end
            OP_SHR: begin
                res  = {1'b0, x[DW-1:1]};
                cout = x[0];
            end
            OP_SHRC: begin
                res  = {cin, x[DW-1:1]};
                cout = x[0];
            end
            OP_ADD, OP_ADDC: begin
                res  = sum_t[DW-1:0];
                cout = |sum_t[XW-1:DW];
            end
            OP_SUB, OP_SUBC: begin
                res  = diff_t[DW-1:0];
                cout = |diff_t[XW-1:DW];
            end
            OP_DEC:  res = x - {{(DW-1){1'b0}}, 1'b1};
            OP_INC:  res = x + {{(DW-1){1'b0}}, 1'b1};
            OP_ONES: res = '1;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/skip_alu_bitunit.sv
module skip_alu_bitunit #(
    parameter int DW    = 8,
    parameter int BIT_W = $clog2(DW)
) (
    input  logic [DW-1:0]    x,
    input  logic [BIT_W-1:0] idx,
    input  logic             bval,
    output logic [DW-1:0]    modified,
    output logic             picked
);

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign modified[g] = (idx == BIT_W'(g)) ? bval : x[g];
    end

    assign picked = x[idx];

endmodule

// File: rtl/skip_alu.sv
module skip_alu
    import skip_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DW-1:0]      acc_i,
    input  logic [DW-1:0]      opnd_i,
    input  logic               carry_i,
    output logic               valid_o,
    output logic [DW-1:0]      result_o,
    output logic               dest_mem_o,
    output logic               acc_we_o,
    output logic               mem_we_o,
    output logic               carry_o,
    output logic               zero_o,
    output logic               neg_o,
    output logic               flag_we_o,
    output logic               skip_o
);

    localparam int BIT_W = $clog2(DW);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] res;
        logic          dest_mem;
        logic          acc_we;
        logic          mem_we;
        logic          carry;
        logic          zero;
        logic          neg;
        logic          flag_we;
        logic          skip;
    } state_t;

    state_t        st_d;
    state_t        st_q;
    dec_t          dec;
    logic [DW-1:0] core_res;
    logic          core_c;
    logic [DW-1:0] bit_mod;
    logic          bit_pick;
    logic          core_z;

    skip_alu_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    skip_alu_core #(.DW(DW)) u_core (
        .op     (dec.op),
        .to_mem (dec.to_mem),
        .a      (acc_i),
        .x      (opnd_i),
        .cin    (carry_i),
        .res    (core_res),
        .cout   (core_c)
    );

    skip_alu_bitunit #(.DW(DW), .BIT_W(BIT_W)) u_bits (
        .x        (opnd_i),
        .idx      (dec.bidx[BIT_W-1:0]),
        .bval     (dec.bval),
        .modified (bit_mod),
        .picked   (bit_pick)
    );

    assign core_z = (core_res == '0);

    always_comb begin
        st_d       = '0;
        st_d.carry = carry_i;
        if (in_valid) begin
            st_d.valid = 1'b1;
            case (dec.cls)
                CL_ALU: begin
                    st_d.res      = core_res;
                    st_d.carry    = core_c;
                    st_d.flag_we  = 1'b1;
                    st_d.zero     = core_z;
                    st_d.neg      = core_res[DW-1];
                    st_d.dest_mem = dec.to_mem;
                    st_d.mem_we   = dec.to_mem;
                    st_d.acc_we   = ~dec.to_mem;
                    case (dec.zskip)
                        ZS_ON_CLEAR: st_d.skip = ~core_z;
                        ZS_ON_SET:   st_d.skip = core_z;
                        default:     st_d.skip = 1'b0;
                    endcase
                end
                CL_PORTIN: begin
                    st_d.res     = opnd_i;
                    st_d.flag_we = 1'b1;
                    st_d.zero    = (opnd_i == '0);
                    st_d.neg     = opnd_i[DW-1];
                    st_d.acc_we  = 1'b1;
                end
                CL_BTEST: begin
                    st_d.skip = (bit_pick == dec.bval);
                end
                CL_BMOD: begin
                    st_d.res      = bit_mod;
                    st_d.dest_mem = 1'b1;
                    st_d.mem_we   = 1'b1;
                end
                default: begin
                    st_d.skip = 1'b0;
                end
            endcase
        end else begin
            st_d.carry = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o    = st_q.valid;
    assign result_o   = st_q.res;
    assign dest_mem_o = st_q.dest_mem;
    assign acc_we_o   = st_q.acc_we;
    assign mem_we_o   = st_q.mem_we;
    assign carry_o    = st_q.carry;
    assign zero_o     = st_q.zero;
    assign neg_o      = st_q.neg;
    assign flag_we_o  = st_q.flag_we;
    assign skip_o     = st_q.skip;

endmodule

// File: rtl/skip_alu_chk.sv
module skip_alu_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [7:0]    op_hi,
    input logic          carry_i,
    input logic          valid_o,
    input logic [DW-1:0] result_o,
    input logic          dest_mem_o,
    input logic          acc_we_o,
    input logic          mem_we_o,
    input logic          carry_o,
    input logic          zero_o,
    input logic          neg_o,
    input logic          flag_we_o,
    input logic          skip_o
);

    p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |-> (!mem_we_o && !dest_mem_o));

    p_mem_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> dest_mem_o);

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (zero_o == (result_o == '0)));

    p_neg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (neg_o == result_o[DW-1]));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!valid_o && !acc_we_o && !mem_we_o && !skip_o && !flag_we_o));

    p_invalid_out_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!acc_we_o && !mem_we_o && !skip_o));

    p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_hi[7:4] == 4'h0) |=>
        (!acc_we_o && !mem_we_o && !skip_o && !flag_we_o && carry_o == $past(carry_i)));

    p_logic_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_hi[7] && (op_hi[6] || op_hi[5]) && op_hi[3:2] == 2'b00) |=>
        (carry_o == $past(carry_i)));

    p_never_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_hi[7:5] == 3'b101) |=> !skip_o);

    p_skip_zclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_hi[7:5] == 3'b111) |=> (skip_o == !zero_o));

    p_skip_zset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_hi[7:5] == 3'b110) |=> (skip_o == zero_o));

    p_btest_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_hi[7:5] == 3'b010) |=> (!acc_we_o && !mem_we_o && !flag_we_o));

endmodule

bind skip_alu skip_alu_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_hi      (instr[15:8]),
    .carry_i    (carry_i),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .dest_mem_o (dest_mem_o),
    .acc_we_o   (acc_we_o),
    .mem_we_o   (mem_we_o),
    .carry_o    (carry_o),
    .zero_o     (zero_o),
    .neg_o      (neg_o),
    .flag_we_o  (flag_we_o),
    .skip_o     (skip_o)
);

// File: tb/test_skip_alu.sv
`timescale 1ns/1ps
module test_skip_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  opnd_i = '0;
    logic        carry_i = 1'b0;
    logic        valid_o, dest_mem_o, acc_we_o, mem_we_o, carry_o;
    logic        zero_o, neg_o, flag_we_o, skip_o;
    logic [7:0]  result_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // expected outputs for the next compare
    int e_valid = 0, e_res = 0, e_dest = 0, e_acc = 0, e_mem = 0;
    int e_c = 0, e_z = 0, e_n = 0, e_fwe = 0, e_skip = 0;
    string t_op = "R1", t_dst = "R1", t_flg = "R1", t_skp = "R1";

    always #2.5 clk = ~clk;

    skip_alu i_skip_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
        .valid_o(valid_o), .result_o(result_o), .dest_mem_o(dest_mem_o),
        .acc_we_o(acc_we_o), .mem_we_o(mem_we_o), .carry_o(carry_o),
        .zero_o(zero_o), .neg_o(neg_o), .flag_we_o(flag_we_o), .skip_o(skip_o)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s instr-prev got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk(t_dst, "valid",    int'(valid_o),    e_valid);
        chk(t_dst, "acc_we",   int'(acc_we_o),   e_acc);
        chk(t_dst, "mem_we",   int'(mem_we_o),   e_mem);
        chk(t_dst, "dest_mem", int'(dest_mem_o), e_dest);
        chk(t_op,  "result",   int'(result_o),   e_res);
        chk(t_op,  "carry",    int'(carry_o),    e_c);
        chk(t_flg, "flag_we",  int'(flag_we_o),  e_fwe);
        chk(t_flg, "zero",     int'(zero_o),     e_z);
        chk(t_flg, "neg",      int'(neg_o),      e_n);
        chk(t_skp, "skip",     int'(skip_o),     e_skip);
    endtask

    function automatic string op_tag(input int op);
        if (op <= 3) return "R3";
        if (op <= 7) return "R4";
        if (op == 8 || op == 9 || op == 12 || op == 13) return "R5";
        return "R6";
    endfunction

    task automatic set_flags(input int r);
        e_fwe = 1;
        e_z = (r == 0) ? 1 : 0;
        e_n = (r >> 7) & 1;
        t_flg = "R7";
    endtask

    // behavioural model of the ALU operations
    task automatic model_alu(input int op, input int dst, input int a, input int x, input int c);
        int r;
        int nc;
        r = 0;
        nc = c;
        case (op)
            0: r = dst ? a : x;
            1: r = a ^ x;
            2: r = a & x;
            3: r = a | x;
            4: begin r = (x * 2) % 256; nc = x / 128; end
            5: begin r = (x * 2 + c) % 256; nc = x / 128; end
            6: begin r = x / 2; nc = x % 2; end
            7: begin r = x / 2 + c * 128; nc = x % 2; end
            8: begin r = (a + x) % 256; nc = (a + x > 255) ? 1 : 0; end
            9: begin r = (a - x + 256) % 256; nc = (a >= x) ? 1 : 0; end
            10: r = (x + 255) % 256;
            11: r = (x + 1) % 256;
            12: begin r = (a + x + c) % 256; nc = (a + x + c > 255) ? 1 : 0; end
            13: begin r = (a - x + c + 256) % 256; nc = (a + c >= x) ? 1 : 0; end
            14: r = 255;
            default: r = 0;
        endcase
        e_res = r;
        e_c = nc;
        set_flags(r);
        t_op = op_tag(op);
        t_dst = "R2";
        e_dest = dst;
        e_mem = dst;
        e_acc = 1 - dst;
    endtask

    task automatic model(input int v, input int ins, input int a, input int x, input int c);
        int nib;
        int op;
        int b;
        nib = (ins >> 12) & 15;
        op = (ins >> 8) & 15;
        b = (ins >> 8) & 7;
        e_valid = v; e_res = 0; e_dest = 0; e_acc = 0; e_mem = 0;
        e_c = c; e_z = 0; e_n = 0; e_fwe = 0; e_skip = 0;
        t_op = "R12"; t_dst = "R12"; t_flg = "R12"; t_skp = "R12";
        if (v == 0) begin
            e_c = 0;
            t_op = "R13"; t_dst = "R13"; t_flg = "R13"; t_skp = "R13";
        end else if (nib >= 10) begin
            model_alu(op, nib % 2, a, x, c);
            t_skp = "R8";
            if (nib >= 14) e_skip = 1 - e_z;
            else if (nib >= 12) e_skip = e_z;
        end else if (nib == 8 || nib == 9) begin
            if (op < 14) begin
                model_alu(op, 0, a, x, c);
                t_skp = "R8";
            end else begin
                t_op = "R9"; t_dst = "R9"; t_flg = "R9"; t_skp = "R9";
                if (nib == 9 && op == 15) begin
                    e_res = x; e_acc = 1;
                    set_flags(x);
                end
            end
        end else if (nib == 4 || nib == 5) begin
            t_op = "R10"; t_dst = "R10"; t_flg = "R10"; t_skp = "R10";
            if (nib == 5) e_skip = (((x >> b) & 1) == 0) ? 1 : 0;
            else e_skip = ((x >> b) & 1);
        end else if (nib == 2 || nib == 3) begin
            t_op = "R11"; t_dst = "R11"; t_flg = "R11"; t_skp = "R11";
            if (nib == 3) e_res = x | (1 << b);
            else e_res = x & (255 - (1 << b));
            e_mem = 1; e_dest = 1;
        end
    endtask

    task automatic step(input bit v, input logic [15:0] ins, input logic [7:0] a,
                        input logic [7:0] x, input bit c);
        @(negedge clk);
        compare_all();
        in_valid = v; instr = ins; acc_i = a; opnd_i = x; carry_i = c;
        model(int'(v), int'(ins), int'(a), int'(x), int'(c));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all();              // R1: reset state while reset held
        rst_n = 1'b1;
        // R3 logic and move
        step(1, 16'hA012, 8'h55, 8'h12, 0);
        step(1, 16'hB012, 8'h55, 8'h12, 1);
        step(1, 16'hA100, 8'hF0, 8'h0F, 1);
        step(1, 16'hA200, 8'hF0, 8'h3C, 0);
        step(1, 16'hB300, 8'h00, 8'h00, 1);
        step(0, 16'hA300, 8'h11, 8'h22, 1);   // R13 idle
        // R4 rotates
        step(1, 16'hA400, 8'h00, 8'h81, 0);
        step(1, 16'hA500, 8'h00, 8'h81, 1);
        step(1, 16'hA600, 8'h00, 8'h01, 0);
        step(1, 16'hB700, 8'h00, 8'h02, 1);
        // R5 arithmetic corners
        step(1, 16'hA800, 8'h80, 8'h80, 0);
        step(1, 16'hA900, 8'h33, 8'h33, 0);
        step(1, 16'hA900, 8'h10, 8'h20, 1);
        step(1, 16'hAC00, 8'hFF, 8'h00, 1);
        step(1, 16'hAD00, 8'h10, 8'h10, 0);
        step(1, 16'hAD00, 8'h10, 8'h11, 1);
        step(1, 16'hBD00, 8'h10, 8'h12, 1);
        // R6
        step(1, 16'hAA00, 8'h00, 8'h00, 1);
        step(1, 16'hAB00, 8'h00, 8'hFF, 0);
        step(1, 16'hAE00, 8'h00, 8'h00, 1);
        step(1, 16'hBF00, 8'h00, 8'h77, 1);
        // R8 skip conditions on the new zero flag
        step(1, 16'hEB00, 8'h00, 8'hFF, 0);
        step(1, 16'hEB00, 8'h00, 8'h00, 0);
        step(1, 16'hFB00, 8'h00, 8'h05, 0);
        step(1, 16'hCB00, 8'h00, 8'hFF, 0);
        step(1, 16'hDB00, 8'h00, 8'h00, 0);
        step(1, 16'hAB00, 8'h00, 8'hFF, 0);
        step(1, 16'hBB00, 8'h00, 8'h00, 0);
        // immediate classes and R9
        step(1, 16'h907E, 8'h00, 8'h7E, 0);
        step(1, 16'h8834, 8'h12, 8'h34, 1);
        step(1, 16'h8E00, 8'h12, 8'h34, 1);
        step(1, 16'h8F00, 8'h12, 8'h00, 1);
        step(1, 16'h9E00, 8'h12, 8'h34, 0);
        step(1, 16'h9F00, 8'h12, 8'h80, 1);
        step(1, 16'h9F00, 8'h12, 8'h00, 0);
        // R10 bit tests
        step(1, 16'h5300, 8'h00, 8'h08, 0);
        step(1, 16'h5200, 8'h00, 8'h08, 0);
        step(1, 16'h4300, 8'h00, 8'h08, 0);
        step(1, 16'h4700, 8'h00, 8'h7F, 0);
        step(1, 16'h4B00, 8'h00, 8'h08, 0);
        // R11 bit modify
        step(1, 16'h3500, 8'h00, 8'h00, 1);
        step(1, 16'h2700, 8'h00, 8'hFF, 0);
        // R12 no-operation opcodes
        step(1, 16'h0000, 8'h12, 8'h34, 1);
        step(1, 16'h1200, 8'h12, 8'h34, 0);
        step(1, 16'h6123, 8'h12, 8'h34, 1);
        step(1, 16'h7456, 8'h12, 8'h34, 1);
        // mixed traffic over every class
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 5) != 0, 16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end
        step(0, 16'h0000, 8'h00, 8'h00, 0);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule